// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single requests from an internal port (read or write, byte or halfword, 32-bit address) into cycles on an external asynchronous memory bus. The external bus shares 16 lines between address and data. An address-enable strobe marks the address phase, so an external latch can hold the address while the same lines carry data. Four 128 kB windows are mapped at fixed bases. Each window has its own active-low select line, its own enable and bus width, and its own phase timing.

The bus has no wait input. Every phase length therefore comes from per-window counters that software programs through a small configuration port. A window can be 8 or 16 bits wide. A halfword access to an 8-bit window becomes two byte cycles. A 16-bit window uses active-low byte-lane enables. An 8-bit window drives a separate high address line instead.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset every strobe and select is inactive (`bus_ae`=0, `bus_rd_n`=`bus_wr_n`=1, `bus_cs_n`=4'hF, byte enables 1, `bus_a16`=0, `bus_ad_oe`=0, `req_done`=0). Every window is disabled and its timing word reads as 0x70FF.
- R2: An address selects window r (r = 0..3) when addr[31:28] = r+1 and addr[27:17] = 0. `bus_cs_n[r]` alone is low from the first address cycle through the hold cycle.
- R3: A request that hits no window, or hits a disabled one, produces no bus activity. It gives `req_done`=1 with `req_err`=1 in the next cycle.
- R4: The address phase lasts 1 + timing[14:12] cycles. During it `bus_ae`=1 and `bus_ad_oe`=1. A 16-bit window drives addr[16:1] on the bus. An 8-bit window drives the byte address [15:0] and puts byte-address bit 16 on `bus_a16` for the whole cycle.
- R5: The read strobe lasts 1 + timing[3:0] cycles and the write strobe lasts 1 + timing[7:4] cycles. The two strobes are never low together.
- R6: A write drives its data with `bus_ad_oe`=1 through the strobe and hold cycles. A read releases the bus after the address phase and captures `bus_ad_i` on the last strobe cycle.
- R7: With timing[8]=1, one hold cycle follows the strobe. In that cycle the select stays low and both strobes are high.
- R8: With timing[9]=1, one cycle with every select and strobe inactive and the bus released follows each read byte cycle. Writes get no such cycle.
- R9: In a 16-bit window a halfword drives both byte enables low. A byte access at an even address drives only `bus_ble_n` low, and at an odd address only `bus_bhe_n` low. The write byte appears on both lanes and a read byte returns zero-extended. In an 8-bit window both byte enables stay high.
- R10: A halfword access to an 8-bit window makes two byte cycles, at the even address first and then the odd one. Write data goes out as bits [7:0] then bits [15:8]. Read data is {second byte, first byte}, and only one done is raised.
- R11: `req_done` is a one-cycle pulse in the cycle after the last bus cycle, with `req_rdata` valid for reads. A held or repeated request while a cycle is under way has no effect.
- R12: With `cfg_we`=1, `cfg_kind`=0 writes the control bits of window `cfg_sel` (bit0 enable, bit1 16-bit width). `cfg_kind`=1 writes its timing word; bits 15, 11 and 10 of that word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_wdata | input | 16 | Write data |
| req_done | output | 1 | Completion pulse |
| req_err | output | 1 | Request rejected (with done) |
| req_rdata | output | 16 | Read data, valid with done |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Window being configured |
| cfg_kind | input | 1 | 0 = control bits, 1 = timing word |
| cfg_wdata | input | 16 | Configuration value |
| bus_ad_o | output | 16 | Address/data lines, outgoing |
| bus_ad_oe | output | 1 | Drive enable of the address/data lines |
| bus_ad_i | input | 16 | Address/data lines, incoming |
| bus_ae | output | 1 | Address-enable strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs_n | output | 4 | Window selects, active low |
| bus_bhe_n | output | 1 | High byte lane enable, active low |
| bus_ble_n | output | 1 | Low byte lane enable, active low |
| bus_a16 | output | 1 | High address line for 8-bit windows |

## Verification
A wrong phase counter or a wrong latched timing field shows up as a strobe one cycle too long or too short. A per-cycle comparison of every bus pin against a behavioural model catches it in that very cycle. A wrong byte index or lane choice appears as the wrong address or data on the bus during the second byte cycle. It also shows as a misordered `req_rdata` at the done pulse. A stale busy/idle state shows either as a restarted cycle while the request is still held or as a missing done within a few cycles.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int WIN_AW = 17;   // address bits inside one window
  localparam int BUS_W  = 16;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_STRB, PH_HOLD, PH_TURN} phase_t;

  typedef struct packed {
    logic       wide;   // 16-bit window
    logic       en;
  } win_ctrl_t;

  typedef struct packed {
    logic [2:0] ae;
    logic       turn;
    logic       hold;
    logic [3:0] ws;
    logic [3:0] rs;
  } win_tim_t;

  localparam win_tim_t TIM_RST = '{ae: 3'd7, turn: 1'b0, hold: 1'b0, ws: 4'hF, rs: 4'hF};

  typedef struct packed {
    logic              wr;
    logic              half;
    logic [WIN_AW-1:0] addr;
    logic [BUS_W-1:0]  wdata;
    win_ctrl_t         c;
    win_tim_t          t;
  } xfer_t;
endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
  import xbus_pkg::*;
#(
  parameter int NRGN = 4,
  localparam int IW = $clog2(NRGN)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [IW-1:0]         cfg_sel,
  input  logic                  cfg_kind,
  input  logic [15:0]           cfg_wdata,
  output win_ctrl_t [NRGN-1:0]  ctrl,
  output win_tim_t  [NRGN-1:0]  tim
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[15], cfg_wdata[11:10]};

  for (genvar g = 0; g < NRGN; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl[g] <= '0;
        tim[g]  <= TIM_RST;
      end else if (cfg_we && cfg_sel == IW'(g)) begin
        if (!cfg_kind) begin
          ctrl[g].en   <= cfg_wdata[0];
          ctrl[g].wide <= cfg_wdata[1];
        end else begin
          tim[g].ae   <= cfg_wdata[14:12];
          tim[g].turn <= cfg_wdata[9];
          tim[g].hold <= cfg_wdata[8];
          tim[g].ws   <= cfg_wdata[7:4];
          tim[g].rs   <= cfg_wdata[3:0];
        end
      end
    end
  end
endmodule

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int NRGN = 4,
  parameter int AW   = 32,
  localparam int HB = AW - WIN_AW,
  localparam int IW = $clog2(NRGN)
) (
  input  logic [HB-1:0] addr_hi,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [NRGN-1:0] match;

  for (genvar g = 0; g < NRGN; g++) begin : g_match
    // window g sits at (g+1) << 28
    assign match[g] = (addr_hi == HB'((g + 1) << (HB - 4)));
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = 0; i < NRGN; i++) begin
      if (match[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int NRGN = 4,
  localparam int IW = $clog2(NRGN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WIN_AW-1:0] req_addr,
  input  logic              req_half,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic              sel_hit,
  input  logic [IW-1:0]     sel_idx,
  input  win_ctrl_t         sel_ctrl,
  input  win_tim_t          sel_tim,
  input  logic [BUS_W-1:0]  bus_ad_i,
  output logic              done,
  output logic              err,
  output logic [BUS_W-1:0]  rdata,
  output logic [BUS_W-1:0]  bus_ad_o,
  output logic              bus_ad_oe,
  output logic              bus_ae,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [NRGN-1:0]   bus_cs_n,
  output logic              bus_bhe_n,
  output logic              bus_ble_n,
  output logic              bus_a16
);
  phase_t            ph, n_ph;
  logic [3:0]        cnt, n_cnt;
  logic              sec, n_sec;
  logic [IW-1:0]     rgn, n_rgn;
  xfer_t             cx, n_cx;
  logic [BUS_W-1:0]  rbuf, n_rbuf;
  logic              fin, reject, wrap;

  // next-state sequencing
  always_comb begin
    n_ph = ph; n_cnt = cnt; n_sec = sec; n_rgn = rgn; n_cx = cx; n_rbuf = rbuf;
    fin = 1'b0; reject = 1'b0; wrap = 1'b0;
    case (ph)
      PH_IDLE: if (req_valid && !done) begin
        if (sel_hit && sel_ctrl.en) begin
          n_cx.wr = req_write;  n_cx.half = req_half;
          n_cx.addr = req_addr; n_cx.wdata = req_wdata;
          n_cx.c = sel_ctrl;    n_cx.t = sel_tim;
          n_rgn = sel_idx; n_ph = PH_ADDR; n_sec = 1'b0;
          n_cnt = {1'b0, sel_tim.ae}; n_rbuf = '0;
        end else begin
          reject = 1'b1;
        end
      end
      PH_ADDR: if (cnt != 0) n_cnt = cnt - 4'd1;
               else begin n_ph = PH_STRB; n_cnt = cx.wr ? cx.t.ws : cx.t.rs; end
      PH_STRB: if (cnt != 0) n_cnt = cnt - 4'd1;
               else begin
                 if (!cx.wr) begin
                   if (cx.c.wide)
                     n_rbuf = cx.half ? bus_ad_i
                            : {8'h00, cx.addr[0] ? bus_ad_i[15:8] : bus_ad_i[7:0]};
                   else if (sec) n_rbuf = {bus_ad_i[7:0], rbuf[7:0]};
                   else          n_rbuf = {8'h00, bus_ad_i[7:0]};
                 end
                 if (cx.t.hold)                n_ph = PH_HOLD;
                 else if (!cx.wr && cx.t.turn) n_ph = PH_TURN;
                 else                          wrap = 1'b1;
               end
      PH_HOLD: if (!cx.wr && cx.t.turn) n_ph = PH_TURN; else wrap = 1'b1;
      PH_TURN: wrap = 1'b1;
      default: n_ph = PH_IDLE;
    endcase
    if (wrap) begin
      if (!cx.c.wide && cx.half && !sec) begin
        n_ph = PH_ADDR; n_sec = 1'b1; n_cnt = {1'b0, cx.t.ae};
      end else begin
        n_ph = PH_IDLE; fin = 1'b1;
      end
    end
  end

  // pin values for the upcoming cycle
  logic [WIN_AW-1:0] p_badr;
  logic [BUS_W-1:0]  p_dat, p_ad;
  logic              p_act, p_drv;
  logic [NRGN-1:0]   p_cs;
  always_comb begin
    p_badr = n_cx.half ? {n_cx.addr[WIN_AW-1:1], n_sec} : n_cx.addr;
    p_act  = (n_ph == PH_ADDR) || (n_ph == PH_STRB) || (n_ph == PH_HOLD);
    p_drv  = ((n_ph == PH_STRB) || (n_ph == PH_HOLD)) && n_cx.wr;
    if (n_cx.c.wide) p_dat = n_cx.half ? n_cx.wdata : {2{n_cx.wdata[7:0]}};
    else             p_dat = {8'h00, n_sec ? n_cx.wdata[15:8] : n_cx.wdata[7:0]};
    if (n_ph == PH_ADDR) p_ad = n_cx.c.wide ? n_cx.addr[WIN_AW-1:1] : p_badr[BUS_W-1:0];
    else if (p_drv)      p_ad = p_dat;
    else                 p_ad = '0;
    p_cs = '1;
    if (p_act) p_cs[n_rgn] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; cnt <= '0; sec <= 1'b0; rgn <= '0; cx <= '0; rbuf <= '0;
      done <= 1'b0; err <= 1'b0; rdata <= '0;
      bus_ad_o <= '0; bus_ad_oe <= 1'b0; bus_ae <= 1'b0;
      bus_rd_n <= 1'b1; bus_wr_n <= 1'b1; bus_cs_n <= '1;
      bus_bhe_n <= 1'b1; bus_ble_n <= 1'b1; bus_a16 <= 1'b0;
    end else begin
      ph <= n_ph; cnt <= n_cnt; sec <= n_sec; rgn <= n_rgn; cx <= n_cx; rbuf <= n_rbuf;
      done <= fin | reject;
      err  <= reject;
      if (fin)         rdata <= n_rbuf;
      else if (reject) rdata <= '0;
      bus_ae    <= (n_ph == PH_ADDR);
      bus_rd_n  <= !((n_ph == PH_STRB) && !n_cx.wr);
      bus_wr_n  <= !((n_ph == PH_STRB) && n_cx.wr);
      bus_ad_oe <= (n_ph == PH_ADDR) || p_drv;
      bus_ad_o  <= p_ad;
      bus_cs_n  <= p_cs;
      bus_a16   <= p_act && !n_cx.c.wide && p_badr[WIN_AW-1];
      bus_bhe_n <= !(p_act && n_cx.c.wide && (n_cx.half || n_cx.addr[0]));
      bus_ble_n <= !(p_act && n_cx.c.wide && (n_cx.half || !n_cx.addr[0]));
    end
  end

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));
  assert_cs_single_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n));
  assert_strobe_has_cs_R2: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n) |-> (bus_cs_n != '1));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_read_float_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_ad_oe);
  assert_ae_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    bus_ae |-> (bus_rd_n && bus_wr_n && bus_ad_oe));
  assert_reject_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && bus_cs_n == '1 && !bus_ae));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int NRGN = 4,
  parameter int AW   = 32,
  localparam int IW = $clog2(NRGN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_half,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              req_done,
  output logic              req_err,
  output logic [BUS_W-1:0]  req_rdata,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_sel,
  input  logic              cfg_kind,
  input  logic [15:0]       cfg_wdata,
  output logic [BUS_W-1:0]  bus_ad_o,
  output logic              bus_ad_oe,
  input  logic [BUS_W-1:0]  bus_ad_i,
  output logic              bus_ae,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [NRGN-1:0]   bus_cs_n,
  output logic              bus_bhe_n,
  output logic              bus_ble_n,
  output logic              bus_a16
);
  win_ctrl_t [NRGN-1:0] ctrl;
  win_tim_t  [NRGN-1:0] tim;
  logic                 hit;
  logic [IW-1:0]        idx;

  xbus_cfg_regs #(.NRGN(NRGN)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata), .ctrl(ctrl), .tim(tim));

  xbus_decode #(.NRGN(NRGN), .AW(AW)) u_dec (
    .addr_hi(req_addr[AW-1:WIN_AW]), .hit(hit), .idx(idx));

  xbus_seq #(.NRGN(NRGN)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr[WIN_AW-1:0]), .req_half(req_half), .req_wdata(req_wdata),
    .sel_hit(hit), .sel_idx(idx), .sel_ctrl(ctrl[idx]), .sel_tim(tim[idx]),
    .bus_ad_i(bus_ad_i), .done(req_done), .err(req_err), .rdata(req_rdata),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ae(bus_ae),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_cs_n(bus_cs_n),
    .bus_bhe_n(bus_bhe_n), .bus_ble_n(bus_ble_n), .bus_a16(bus_a16));
endmodule

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 0, req_write = 0, req_half = 0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_done, req_err;
  logic [15:0] req_rdata;
  logic        cfg_we = 0, cfg_kind = 0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] bus_ad_o, bus_ad_i;
  logic        bus_ad_oe, bus_ae, bus_rd_n, bus_wr_n, bus_bhe_n, bus_ble_n, bus_a16;
  logic [3:0]  bus_cs_n;

  int checks = 0, fails = 0;
  logic [1:0]  s_ctrl [4];
  logic [15:0] s_tim  [4];
  logic [15:0] lat = '0;

  always #10 clk = ~clk;

  xbus_ctrl dut (.*);

  // external device: latches the address under AE, answers reads from it
  always @(negedge clk) if (bus_ae) lat <= bus_ad_o;
  assign bus_ad_i = !bus_rd_n ? {~lat[7:0], lat[7:0] ^ 8'h3C} : 16'h0000;

  task automatic chk(input string tag, input logic e_ae, e_rd, e_wr, input logic [3:0] e_cs,
                     input logic e_oe, input logic [15:0] e_ad, input logic e_bhe, e_ble, e_a16,
                     input logic e_done, e_err, e_rv, input logic [15:0] e_rdata);
    logic [12:0] got, exp;
    @(negedge clk);
    checks++;
    got = {bus_ae, bus_rd_n, bus_wr_n, bus_cs_n, bus_ad_oe, bus_bhe_n, bus_ble_n, bus_a16, req_done, req_err};
    exp = {e_ae, e_rd, e_wr, e_cs, e_oe, e_bhe, e_ble, e_a16, e_done, e_err};
    if (got !== exp || (e_oe && bus_ad_o !== e_ad) || (e_rv && req_rdata !== e_rdata)) begin
      fails++;
      $display("FAIL %s: pins=%b ad=%h rdata=%h expected pins=%b ad=%h rdata=%h",
               tag, got, bus_ad_o, req_rdata, exp, e_ad, e_rdata);
    end
  endtask

  task automatic idle_chk(input string tag);
    chk(tag, 0, 1, 1, 4'hF, 0, 16'h0, 1, 1, 0, 0, 0, 0, 16'h0);
  endtask

  task automatic cfg(input int r, input logic kind, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(r); cfg_kind = kind; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    if (kind) s_tim[r] = v & 16'h73FF; else s_ctrl[r] = v[1:0];
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic half,
                        input logic [15:0] wd, input string tag);
    int r; logic ok, wide, hold, turn; int ae, sl, ncyc;
    logic [16:0] ba; logic [15:0] ado, dat, er; logic bhe, ble, a16e; logic [3:0] cs;
    ok = (a[31:28] >= 4'd1 && a[31:28] <= 4'd4 && a[27:17] == 11'd0);
    r  = ok ? int'(a[31:28]) - 1 : 0;
    ok = ok && s_ctrl[r][0];
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_half = half; req_wdata = wd;
    if (!ok) begin
      chk({"R3 ", tag}, 0, 1, 1, 4'hF, 0, 16'h0, 1, 1, 0, 1, 1, 1, 16'h0);
      req_valid = 0;
      idle_chk({"R11 ", tag});
      return;
    end
    wide = s_ctrl[r][1]; ae = int'(s_tim[r][14:12]);
    hold = s_tim[r][8]; turn = s_tim[r][9];
    sl = wr ? int'(s_tim[r][7:4]) : int'(s_tim[r][3:0]);
    ncyc = (!wide && half) ? 2 : 1;
    er = '0;
    cs = 4'hF & ~(4'b0001 << r);
    for (int c = 0; c < ncyc; c++) begin
      ba   = (half && !wide) ? {a[16:1], c[0]} : a[16:0];
      ado  = wide ? a[16:1] : ba[15:0];
      a16e = !wide && ba[16];
      bhe  = !(wide && (half || a[0]));
      ble  = !(wide && (half || !a[0]));
      dat  = wide ? (half ? wd : {wd[7:0], wd[7:0]}) : {8'h00, (c == 1) ? wd[15:8] : wd[7:0]};
      for (int i = 0; i <= ae; i++)
        chk({"R4 ", tag}, 1, 1, 1, cs, 1, ado, bhe, ble, a16e, 0, 0, 0, 16'h0);
      for (int i = 0; i <= sl; i++)
        chk({"R5 ", tag}, 0, wr, !wr, cs, wr, dat, bhe, ble, a16e, 0, 0, 0, 16'h0);
      if (hold)
        chk({"R7 ", tag}, 0, 1, 1, cs, wr, dat, bhe, ble, a16e, 0, 0, 0, 16'h0);
      if (!wr && turn)
        chk({"R8 ", tag}, 0, 1, 1, 4'hF, 0, 16'h0, 1, 1, 0, 0, 0, 0, 16'h0);
      if (!wr) begin
        if (wide) er = half ? {~ado[7:0], ado[7:0] ^ 8'h3C}
                            : {8'h00, a[0] ? ~ado[7:0] : ado[7:0] ^ 8'h3C};
        else if (c == 0) er = {8'h00, ado[7:0] ^ 8'h3C};
        else er[15:8] = ado[7:0] ^ 8'h3C;
      end
    end
    chk({"R11 ", tag}, 0, 1, 1, 4'hF, 0, 16'h0, 1, 1, 0, 1, 0, !wr, er);
    req_valid = 0;
    idle_chk({"R11 ", tag});
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin s_ctrl[i] = 2'b00; s_tim[i] = 16'h70FF; end
    repeat (3) @(negedge clk);
    rst = 0;
    idle_chk("R1 reset");
    idle_chk("R1 reset");
    // window 0: enabled, 16-bit, reset timing still in place
    cfg(0, 0, 16'h0003);
    access(0, 32'h1000_0002, 1, 16'h0, "R1 reset timing read");
    // rejected requests
    access(0, 32'h5000_0000, 1, 16'h0, "R3 unmapped");
    access(0, 32'h1002_0000, 1, 16'h0, "R3 above window");
    access(1, 32'h2000_0010, 1, 16'h1234, "R3 disabled window");
    // window 0 with short timing, hold and turnaround
    cfg(0, 1, 16'h2331);  // ae=2 turn=1 hold=1 ws=3 rs=1
    access(1, 32'h1001_2346, 1, 16'hBEEF, "R6 R7 R9 write half");
    access(0, 32'h1001_2346, 1, 16'h0, "R8 R6 read half");
    access(1, 32'h1000_0101, 0, 16'h00A5, "R9 write odd byte");
    access(0, 32'h1000_0101, 0, 16'h0, "R9 read odd byte");
    access(0, 32'h1000_0100, 0, 16'h0, "R9 read even byte");
    // window 2: 8-bit with split halfwords
    cfg(2, 0, 16'h0001);
    cfg(2, 1, 16'h0201);  // ae=0 turn=1 rs=1 ws=0
    access(0, 32'h3001_2345, 1, 16'h0, "R10 read half split");
    access(1, 32'h3001_2344, 1, 16'hC3D2, "R10 write half split");
    access(0, 32'h3000_0077, 0, 16'h0, "R4 R2 narrow byte read");
    // window 3: minimum timing, ignored bits set
    cfg(3, 0, 16'h0003);
    cfg(3, 1, 16'h8C00);  // only ignored bits set -> all fields zero
    access(0, 32'h4000_0AB0, 1, 16'h0, "R12 R5 minimum read");
    access(1, 32'h4000_0AB0, 1, 16'h5A5A, "R2 R5 minimum write");
    // disable window 0 again
    cfg(0, 0, 16'h0002);
    access(0, 32'h1000_0000, 1, 16'h0, "R12 disabled again");
    idle_chk("R1 final idle");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule